// File: doc/BRIEF.md
# Aligned Dual-Issue Pair Gate

This block sits between decode and execute in a two-way in-order pipeline. Each cycle it looks at one fetched pair of 32-bit instructions. It decides whether both instructions go to execute in that cycle, or whether only the first goes and the second follows one cycle later. Two instructions may issue together only when the first one sits on an 8-byte boundary. When the second instruction reads a register that the first one writes, or when the two need the same single resource, only the second instruction is held back.

The block models two ALU slots, one data-cache port and one multiply/divide unit. Upstream decode supplies a 3-bit class code for each instruction: 0 alu, 1 load, 2 store, 3 multiply, 4 divide, 5 HI/LO move, 6 branch/jump/call, 7 multi-cycle or unknown. Upstream also supplies the first instruction's destination register and the second instruction's two source registers. A small two-state machine handles the split case. `GATE_OPEN` judges new pairs. On a structural or register conflict at an aligned address it takes the transition `SPLIT_PAIR` into `GATE_SPLIT`. There it releases slot 1 alone and takes the transition `REJOIN` back to `GATE_OPEN`. While `hold_slot1` is high, upstream keeps the pair steady and presents it again in the next cycle.

Top module: `dual_issue_pair_gate`

## Requirements
- R1: In `GATE_OPEN`, a valid pair at an aligned address (`pair_addr_lo` == 0) with no conflict raises `issue_slot0` and `issue_slot1` in the same cycle, with `hold_slot1` low. Examples of such pairs are alu+load and load+multiply.
- R2: In `GATE_OPEN`, a valid pair at any address with `pair_addr_lo` != 0 issues only slot 0: `issue_slot0`=1, `issue_slot1`=0, `hold_slot1`=0. The state stays `GATE_OPEN`, whatever the classes and registers are.
- R3: At an aligned address, if `slot1_src_a` or `slot1_src_b` equals a nonzero `slot0_dst`, the outputs are `issue_slot0`=1, `issue_slot1`=0 and `hold_slot1`=1 in that cycle.
- R4: Register 0 never creates a dependence. When `slot0_dst`=0, a pair with no other conflict issues both slots, even if a source equals 0.
- R5: Two memory-class instructions (classes 1 and 2, in any combination) at an aligned address conflict on the single cache port, so slot 1 is held.
- R6: Two instructions from the multiply/divide group (classes 3, 4 and 5, in any combination) at an aligned address conflict, so slot 1 is held.
- R7: Class 7 in either slot at an aligned address reserves every unit, so slot 1 is held.
- R8: A branch (class 6) takes one ALU. Branch+alu and branch+branch pairs issue together, because two ALUs exist.
- R9: The cycle after `hold_slot1`=1, the outputs are `issue_slot1`=1, `issue_slot0`=0 and `hold_slot1`=0, whatever the inputs are. The next cycle judges a fresh pair in `GATE_OPEN`.
- R10: With `pair_valid`=0 in `GATE_OPEN`, all three outputs are 0.
- R11: During reset, and right after it, the block is in `GATE_OPEN` and all outputs are 0 while `pair_valid` is low. `hold_slot1` is never high together with `issue_slot1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pair_valid | input | 1 | A fetched pair is presented |
| pair_addr_lo | input | 3 | Low bits of the first instruction's fetch address |
| slot0_cls | input | 3 | Class code of the first instruction |
| slot1_cls | input | 3 | Class code of the second instruction |
| slot0_dst | input | 5 | Destination register of the first instruction (0 = none) |
| slot1_src_a | input | 5 | First source register of the second instruction |
| slot1_src_b | input | 5 | Second source register of the second instruction |
| issue_slot0 | output | 1 | First instruction issues this cycle |
| issue_slot1 | output | 1 | Second instruction issues this cycle |
| hold_slot1 | output | 1 | Second instruction is held; pair must be presented again |

## Verification
Directed pairs cover each class combination that separates pairing from splitting. Same-resource pairs for the cache port and for the multiply/divide unit are set against mixed-resource pairs. Branch pairs show that the two ALUs really exist, and multi-class instructions are placed in each slot. Register cases separate a match on source A from a match on source B, and both from a write to register 0. Unaligned addresses are tried with pairs that would otherwise conflict, which shows that alignment is checked before anything else. A long random run uses a small register range, so that dependences happen often. It also puts new inputs on the cycle after a split, which shows that the held cycle ignores them.

// File: rtl/iss_pkg.sv
package iss_pkg;

    typedef enum logic [2:0] {
        CLS_ALU    = 3'd0,
        CLS_LOAD   = 3'd1,
        CLS_STORE  = 3'd2,
        CLS_MUL    = 3'd3,
        CLS_DIV    = 3'd4,
        CLS_HILO   = 3'd5,
        CLS_BRANCH = 3'd6,
        CLS_MULTI  = 3'd7
    } iss_cls_e;

    localparam int ALU_CNT_W = 2;

    // Resources one instruction claims in the issue cycle
    typedef struct packed {
        logic [ALU_CNT_W-1:0] alu_n;
        logic                 cache;
        logic                 muldiv;
        logic                 whole;
    } res_use_t;

    typedef enum logic {
        GATE_OPEN  = 1'b0,
        GATE_SPLIT = 1'b1
    } gate_state_e;

endpackage

// File: rtl/iss_res_decode.sv
module iss_res_decode
    import iss_pkg::*;
(
    input  logic [2:0] cls_i,
    output res_use_t   use_o
);

    always_comb begin
        use_o = '0;
        unique case (iss_cls_e'(cls_i))
            CLS_ALU, CLS_BRANCH:    use_o.alu_n  = ALU_CNT_W'(1);
            CLS_LOAD, CLS_STORE:    use_o.cache  = 1'b1;
            CLS_MUL, CLS_DIV,
            CLS_HILO:               use_o.muldiv = 1'b1;
            CLS_MULTI: begin
                use_o.alu_n  = '1;
                use_o.cache  = 1'b1;
                use_o.muldiv = 1'b1;
                use_o.whole  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/iss_hazard_check.sv
module iss_hazard_check #(
    parameter int REG_W = 5,
    parameter int N_SRC = 2
) (
    input  logic [REG_W-1:0]            dst_i,
    input  logic [N_SRC-1:0][REG_W-1:0] src_i,
    output logic                        raw_o
);

    logic [N_SRC-1:0] hit;
    logic             dst_live;

    assign dst_live = (dst_i != '0);

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign hit[g] = dst_live && (src_i[g] == dst_i);
    end

    assign raw_o = |hit;

endmodule

// File: rtl/dual_issue_pair_gate.sv
module dual_issue_pair_gate
    import iss_pkg::*;
#(
    parameter int PAIR_BYTES = 8,
    parameter int REG_W      = 5,
    parameter int NUM_ALU    = 2,
    parameter int CLS_W      = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          pair_valid,
    input  logic [$clog2(PAIR_BYTES)-1:0] pair_addr_lo,
    input  logic [CLS_W-1:0]              slot0_cls,
    input  logic [CLS_W-1:0]              slot1_cls,
    input  logic [REG_W-1:0]              slot0_dst,
    input  logic [REG_W-1:0]              slot1_src_a,
    input  logic [REG_W-1:0]              slot1_src_b,
    output logic                          issue_slot0,
    output logic                          issue_slot1,
    output logic                          hold_slot1
);

    localparam int                 ALIGN_W = $clog2(PAIR_BYTES);
    localparam int                 SUM_W   = ALU_CNT_W + 1;
    localparam logic [SUM_W-1:0]   ALU_LIM = SUM_W'(NUM_ALU);

    res_use_t    use0, use1;
    logic        raw_hit;
    logic        aligned;
    logic        res_clash;
    logic        split_now;
    logic [SUM_W-1:0] alu_sum;
    gate_state_e state_q, state_d;
    logic        in_split;

    // Per-slot resource decode
    iss_res_decode u_dec0 (.cls_i(slot0_cls), .use_o(use0));
    iss_res_decode u_dec1 (.cls_i(slot1_cls), .use_o(use1));

    iss_hazard_check #(.REG_W(REG_W), .N_SRC(2)) u_raw (
        .dst_i (slot0_dst),
        .src_i ({slot1_src_b, slot1_src_a}),
        .raw_o (raw_hit)
    );

    assign aligned   = (pair_addr_lo == ALIGN_W'(0));
    assign alu_sum   = {1'b0, use0.alu_n} + {1'b0, use1.alu_n};
    assign res_clash = use0.whole || use1.whole
                    || (use0.cache && use1.cache)
                    || (use0.muldiv && use1.muldiv)
                    || (alu_sum > ALU_LIM);
    assign split_now = pair_valid && aligned && (res_clash || raw_hit);
    assign in_split  = (state_q == GATE_SPLIT);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GATE_OPEN;
        else        state_q <= state_d;
    end

    // Transitions: SPLIT_PAIR and REJOIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_OPEN:  if (split_now) state_d = GATE_SPLIT;
            GATE_SPLIT: state_d = GATE_OPEN;
        endcase
    end

    // Outputs
    always_comb begin
        issue_slot0 = 1'b0;
        issue_slot1 = 1'b0;
        hold_slot1  = 1'b0;
        unique case (state_q)
            GATE_OPEN: begin
                if (pair_valid) begin
                    issue_slot0 = 1'b1;
                    if (aligned) begin
                        hold_slot1  = split_now;
                        issue_slot1 = !split_now;
                    end
                end
            end
            GATE_SPLIT: issue_slot1 = 1'b1;
        endcase
    end

endmodule

// File: rtl/iss_gate_chk.sv
module iss_gate_chk #(
    parameter int ALIGN_W = 3,
    parameter int REG_W   = 5,
    parameter int CLS_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pair_valid,
    input logic [ALIGN_W-1:0] pair_addr_lo,
    input logic [CLS_W-1:0]   slot0_cls,
    input logic [CLS_W-1:0]   slot1_cls,
    input logic [REG_W-1:0]   slot0_dst,
    input logic [REG_W-1:0]   slot1_src_a,
    input logic               in_split,
    input logic               issue_slot0,
    input logic               issue_slot1,
    input logic               hold_slot1
);

    logic fresh_aligned;
    assign fresh_aligned = !in_split && pair_valid && (pair_addr_lo == '0);

    p_unaligned_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_split && pair_valid && pair_addr_lo != '0)
            |-> (issue_slot0 && !issue_slot1 && !hold_slot1));

    p_raw_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fresh_aligned && slot0_dst != '0 && slot1_src_a == slot0_dst)
            |-> hold_slot1);

    p_cache_port_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fresh_aligned && (slot0_cls == 3'd1 || slot0_cls == 3'd2)
                       && (slot1_cls == 3'd1 || slot1_cls == 3'd2))
            |-> hold_slot1);

    p_multi_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fresh_aligned && (slot0_cls == 3'd7 || slot1_cls == 3'd7))
            |-> hold_slot1);

    p_split_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hold_slot1 |=> (issue_slot1 && !issue_slot0 && !hold_slot1));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_split && !pair_valid)
            |-> !(issue_slot0 || issue_slot1 || hold_slot1));

    p_hold_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hold_slot1 |-> (issue_slot0 && !issue_slot1));

endmodule

bind dual_issue_pair_gate iss_gate_chk #(
    .ALIGN_W ($clog2(PAIR_BYTES)),
    .REG_W   (REG_W),
    .CLS_W   (CLS_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pair_valid   (pair_valid),
    .pair_addr_lo (pair_addr_lo),
    .slot0_cls    (slot0_cls),
    .slot1_cls    (slot1_cls),
    .slot0_dst    (slot0_dst),
    .slot1_src_a  (slot1_src_a),
    .in_split     (in_split),
    .issue_slot0  (issue_slot0),
    .issue_slot1  (issue_slot1),
    .hold_slot1   (hold_slot1)
);

// File: tb/tb_dual_issue_pair_gate.sv
module tb_dual_issue_pair_gate;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pair_valid = 1'b0;
    logic [2:0] pair_addr_lo = '0;
    logic [2:0] slot0_cls = '0;
    logic [2:0] slot1_cls = '0;
    logic [4:0] slot0_dst = '0;
    logic [4:0] slot1_src_a = '0;
    logic [4:0] slot1_src_b = '0;
    logic       issue_slot0, issue_slot1, hold_slot1;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  m_hold = 1'b0;

    always #2 clk = ~clk;

    dual_issue_pair_gate dut (
        .clk(clk), .rst_n(rst_n), .pair_valid(pair_valid),
        .pair_addr_lo(pair_addr_lo), .slot0_cls(slot0_cls),
        .slot1_cls(slot1_cls), .slot0_dst(slot0_dst),
        .slot1_src_a(slot1_src_a), .slot1_src_b(slot1_src_b),
        .issue_slot0(issue_slot0), .issue_slot1(issue_slot1),
        .hold_slot1(hold_slot1)
    );

    function automatic bit is_mem(logic [2:0] c);
        return (c == 3'd1) || (c == 3'd2);
    endfunction

    function automatic bit is_md(logic [2:0] c);
        return (c == 3'd3) || (c == 3'd4) || (c == 3'd5);
    endfunction

    // Expected {issue0, issue1, hold}
    function automatic logic [2:0] model(bit hold, logic v, logic [2:0] a,
            logic [2:0] c0, logic [2:0] c1, logic [4:0] d0,
            logic [4:0] sa, logic [4:0] sb);
        bit clash;
        if (hold) return 3'b010;
        if (!v) return 3'b000;
        if (a != 3'd0) return 3'b100;
        clash = (c0 == 3'd7) || (c1 == 3'd7)
             || (is_mem(c0) && is_mem(c1)) || (is_md(c0) && is_md(c1))
             || (d0 != 5'd0 && (sa == d0 || sb == d0));
        return clash ? 3'b101 : 3'b110;
    endfunction

    function automatic string tag(bit hold, logic v, logic [2:0] a,
            logic [2:0] c0, logic [2:0] c1, logic [4:0] d0,
            logic [4:0] sa, logic [4:0] sb);
        if (hold) return "R9";
        if (!v) return "R10";
        if (a != 3'd0) return "R2";
        if (c0 == 3'd7 || c1 == 3'd7) return "R7";
        if (is_mem(c0) && is_mem(c1)) return "R5";
        if (is_md(c0) && is_md(c1)) return "R6";
        if (d0 != 5'd0 && (sa == d0 || sb == d0)) return "R3";
        if (d0 == 5'd0) return "R4";
        if (c0 == 3'd6 || c1 == 3'd6) return "R8";
        return "R1";
    endfunction

    task automatic apply(logic v, logic [2:0] a, logic [2:0] c0,
            logic [2:0] c1, logic [4:0] d0, logic [4:0] sa, logic [4:0] sb);
        logic [2:0] exp, got;
        string      t;
        @(negedge clk);
        pair_valid = v; pair_addr_lo = a; slot0_cls = c0; slot1_cls = c1;
        slot0_dst = d0; slot1_src_a = sa; slot1_src_b = sb;
        #1;
        exp = model(m_hold, v, a, c0, c1, d0, sa, sb);
        t   = tag(m_hold, v, a, c0, c1, d0, sa, sb);
        got = {issue_slot0, issue_slot1, hold_slot1};
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: {i0,i1,hold} actual=%b expected=%b", t, got, exp);
        end
        m_hold = exp[0];
    endtask

    initial begin
        void'($urandom(32'd4130));
        // R11: reset state
        repeat (3) @(negedge clk);
        #1;
        n_run++;
        if ({issue_slot0, issue_slot1, hold_slot1} !== 3'b000) begin
            n_fail++;
            $display("FAIL R11: actual=%b expected=000",
                     {issue_slot0, issue_slot1, hold_slot1});
        end
        @(negedge clk); rst_n = 1'b1;
        apply(0, 0, 0, 0, 0, 0, 0);            // R11/R10 idle after reset
        apply(1, 0, 0, 1, 3, 1, 2);            // R1 alu+load
        apply(1, 0, 1, 3, 4, 1, 2);            // R1 load+mul
        apply(1, 0, 6, 0, 5, 1, 2);            // R8 branch+alu
        apply(1, 0, 6, 6, 5, 1, 2);            // R8 branch+branch
        apply(1, 4, 1, 1, 3, 3, 3);            // R2 unaligned would-clash
        apply(1, 2, 7, 7, 0, 0, 0);            // R2 unaligned multi
        apply(1, 0, 0, 0, 9, 9, 1);            // R3 src_a match
        apply(1, 4, 7, 1, 9, 9, 9);            // R9 held cycle, inputs ignored
        apply(1, 0, 0, 0, 9, 1, 9);            // R3 src_b match
        apply(0, 0, 0, 0, 0, 0, 0);            // R9 with valid low
        apply(1, 0, 0, 0, 0, 0, 0);            // R4 register 0
        apply(1, 0, 1, 2, 3, 1, 2);            // R5 load+store
        apply(1, 0, 2, 2, 3, 1, 2);            // R9
        apply(1, 0, 3, 5, 3, 1, 2);            // R6 mul+hilo
        apply(1, 0, 4, 3, 3, 1, 2);            // R9
        apply(1, 0, 7, 0, 3, 1, 2);            // R7 multi slot 0
        apply(1, 0, 0, 0, 0, 0, 0);            // R9
        apply(1, 0, 0, 7, 3, 1, 2);            // R7 multi slot 1
        apply(1, 0, 0, 0, 0, 0, 0);            // R9
        apply(0, 0, 3, 3, 3, 3, 3);            // R10
        for (int i = 0; i < 600; i++) begin
            apply(($urandom % 10) != 0,
                  ($urandom % 2) ? 3'd0 : 3'($urandom),
                  3'($urandom), 3'($urandom),
                  5'($urandom % 4), 5'($urandom % 4), 5'($urandom % 4));
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule